// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Repeat Masks

This unit sits next to a BCD time-of-day counter and watches it for an alarm event. Four alarm fields can be written: seconds, minutes, hours and day of month. Bit 7 of each field is a repeat mask. On every once-per-second tick the unit compares the unmasked alarm fields with the live BCD time. When they are equal, it emits a single-cycle interrupt pulse. The pattern of mask bits selects one of five repeat rates: once a month, once a day, once an hour, once a minute or every second. The unit checks each write for a legal BCD value and discards a write that is out of range.

The control is a three-state machine:
- **ST_DISARMED** is the state after reset. It moves to ST_FIRE on a tick that hits if a date has already been accepted. Otherwise it moves to ST_WATCH as soon as a date has been accepted.
- **ST_WATCH** moves to ST_FIRE on a tick that hits.
- **ST_FIRE** drives the pulse and always returns to ST_WATCH on the next cycle.

Ticks are expected at least two clock cycles apart.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset, `alarm_irq` is low and all four alarm fields are zero. No pulse is produced, whatever the masks or the time, until a write to the date field has been accepted.
- R2: Field select 0 is seconds and select 1 is minutes. A write to either is stored only when bits [6:0] form a BCD value from 00 to 59. A rejected write leaves the field unchanged.
- R3: Field select 2 is hours. A write is stored only when bits [5:0] form a BCD value from 00 to 23. A rejected write leaves the field unchanged.
- R4: Field select 3 is the date. A write whose bits [4:0] are zero is rejected and leaves the field unchanged. Any other value is stored.
- R5: With all four mask bits clear, a tick produces a pulse only when seconds [6:0], minutes [6:0], hours [5:0] and date [5:0] all equal the live time.
- R6: With only the date mask set, the date is ignored, and seconds, minutes and hours must match.
- R7: With the date and hour masks set (and the minute and second masks clear), only seconds and minutes must match.
- R8: With the date, hour and minute masks set (and the second mask clear), only seconds must match.
- R9: Any other mask combination produces a pulse on every tick.
- R10: `alarm_irq` is high for exactly the one cycle after the tick that hit. It never rises without a tick in the cycle before.
- R11: A write made in the same cycle as a tick is not seen by that tick's comparison. It takes effect from the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for an alarm field |
| wr_sel | input | 2 | Field select: 0 seconds, 1 minutes, 2 hours, 3 date |
| wr_data | input | 8 | Write value; bit 7 is the repeat mask |
| tick | input | 1 | Once-per-second compare strobe |
| now_sec | input | 8 | Live seconds, BCD |
| now_min | input | 8 | Live minutes, BCD |
| now_hour | input | 8 | Live hours, BCD |
| now_date | input | 8 | Live day of month, BCD |
| alarm_irq | output | 1 | One-cycle alarm pulse |

## Verification
The alarm fields cannot be read back, so the hardest case to observe is a rejected write. The bench sweeps every one of the 256 byte values into each field. Before each value it reloads a zero (or a date of one) into that field. It then ticks with the live time set to the written value, under a mask mode that compares only that field. A pulse therefore occurs exactly when the write was accepted. The expected acceptance is computed from BCD digit arithmetic. Directed ticks cover each repeat rate and the same-cycle write-plus-tick case.

// File: rtl/rtc_alarm_pkg.sv
`timescale 1ns/1ps
package rtc_alarm_pkg;
    localparam int DATA_W     = 8;
    localparam int NUM_FIELDS = 4;
    localparam int SEL_W      = $clog2(NUM_FIELDS);
    localparam int MASK_BIT   = DATA_W - 1;

    localparam logic [SEL_W-1:0] SEL_SEC  = SEL_W'(0);
    localparam logic [SEL_W-1:0] SEL_MIN  = SEL_W'(1);
    localparam logic [SEL_W-1:0] SEL_HOUR = SEL_W'(2);
    localparam logic [SEL_W-1:0] SEL_DATE = SEL_W'(3);

    typedef enum logic [2:0] {
        RATE_MONTHLY,
        RATE_DAILY,
        RATE_HOURLY,
        RATE_MINUTE,
        RATE_EVERY_SEC
    } rate_e;

    typedef enum logic [1:0] {
        ST_DISARMED,
        ST_WATCH,
        ST_FIRE
    } fsm_e;

    // BCD value check: units digit legal, tens below top, or equal to top with bounded units
    function automatic logic bcd_within(input logic [DATA_W-1:0] v,
                                        input logic [3:0] tens_top,
                                        input logic [3:0] units_at_top);
        logic [3:0] tens;
        logic [3:0] units;
        tens  = v[7:4];
        units = v[3:0];
        return (units <= 4'd9) &&
               ((tens < tens_top) || ((tens == tens_top) && (units <= units_at_top)));
    endfunction

    function automatic logic [DATA_W-1:0] field_cmp_mask(input logic [SEL_W-1:0] sel);
        logic [DATA_W-1:0] m;
        unique case (sel)
            SEL_SEC, SEL_MIN: m = 8'h7F;
            default:          m = 8'h3F;
        endcase
        return m;
    endfunction

    function automatic logic field_ok(input logic [SEL_W-1:0] sel,
                                      input logic [DATA_W-1:0] v);
        logic ok;
        unique case (sel)
            SEL_SEC, SEL_MIN: ok = bcd_within(v & 8'h7F, 4'd5, 4'd9);
            SEL_HOUR:         ok = bcd_within(v & 8'h3F, 4'd2, 4'd3);
            default:          ok = (v[4:0] != 5'd0);
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
`timescale 1ns/1ps
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
(
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [SEL_W-1:0]                      wr_sel,
    input  logic [DATA_W-1:0]                     wr_data,
    output logic [NUM_FIELDS-1:0][DATA_W-1:0]     fields,
    output logic                                  armed
);
    logic [NUM_FIELDS-1:0] take;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(g);

        always_comb begin
            take[g] = wr_en && (wr_sel == MY_SEL) && field_ok(MY_SEL, wr_data);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fields[g] <= '0;
            end else if (take[g]) begin
                fields[g] <= wr_data;
            end
        end

        assert_field_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (g != int'(SEL_DATE)) |-> field_ok(MY_SEL, fields[g]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (take[SEL_DATE]) begin
            armed <= 1'b1;
        end
    end

    assert_hour_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fields[SEL_HOUR][3:0] <= 4'd9 && fields[SEL_HOUR][5:0] <= 6'h23);

    assert_date_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (fields[SEL_DATE][4:0] != 5'd0));
endmodule

// File: rtl/rtc_alarm_rate.sv
`timescale 1ns/1ps
module rtc_alarm_rate
    import rtc_alarm_pkg::*;
(
    input  logic [NUM_FIELDS-1:0] masks,
    output rate_e                 rate,
    output logic [NUM_FIELDS-1:0] field_en
);
    logic [3:0] ladder;

    always_comb begin
        ladder = {masks[SEL_DATE], masks[SEL_HOUR], masks[SEL_MIN], masks[SEL_SEC]};
        case (ladder)
            4'b0000: rate = RATE_MONTHLY;
            4'b1000: rate = RATE_DAILY;
            4'b1100: rate = RATE_HOURLY;
            4'b1110: rate = RATE_MINUTE;
            default: rate = RATE_EVERY_SEC;
        endcase
    end

    always_comb begin
        field_en = '0;
        unique case (rate)
            RATE_MONTHLY: begin
                field_en[SEL_SEC]  = 1'b1;
                field_en[SEL_MIN]  = 1'b1;
                field_en[SEL_HOUR] = 1'b1;
                field_en[SEL_DATE] = 1'b1;
            end
            RATE_DAILY: begin
                field_en[SEL_SEC]  = 1'b1;
                field_en[SEL_MIN]  = 1'b1;
                field_en[SEL_HOUR] = 1'b1;
            end
            RATE_HOURLY: begin
                field_en[SEL_SEC]  = 1'b1;
                field_en[SEL_MIN]  = 1'b1;
            end
            RATE_MINUTE: begin
                field_en[SEL_SEC]  = 1'b1;
            end
            default: field_en = '0;
        endcase
    end
endmodule

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_v,
    input  logic [NUM_FIELDS-1:0][DATA_W-1:0] now_v,
    input  logic [NUM_FIELDS-1:0]             field_en,
    output logic                              hit
);
    logic [NUM_FIELDS-1:0] agree;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
        localparam logic [DATA_W-1:0] CMASK = field_cmp_mask(SEL_W'(g));
        always_comb begin
            agree[g] = !field_en[g] || ((alarm_v[g] & CMASK) == (now_v[g] & CMASK));
        end
    end

    always_comb begin
        hit = &agree;
    end
endmodule

// File: rtl/rtc_alarm_unit.sv
`timescale 1ns/1ps
module rtc_alarm_unit
    import rtc_alarm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [7:0]  wr_data,
    input  logic        tick,
    input  logic [7:0]  now_sec,
    input  logic [7:0]  now_min,
    input  logic [7:0]  now_hour,
    input  logic [7:0]  now_date,
    output logic        alarm_irq
);
    logic [NUM_FIELDS-1:0][DATA_W-1:0] fields;
    logic [NUM_FIELDS-1:0][DATA_W-1:0] now_v;
    logic [NUM_FIELDS-1:0]             masks;
    logic [NUM_FIELDS-1:0]             field_en;
    logic                              armed;
    logic                              hit;
    rate_e                             rate;
    fsm_e                              state_q;
    fsm_e                              state_d;

    rtc_alarm_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .fields  (fields),
        .armed   (armed)
    );

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_mask
        always_comb masks[g] = fields[g][MASK_BIT];
    end

    always_comb begin
        now_v[SEL_SEC]  = now_sec;
        now_v[SEL_MIN]  = now_min;
        now_v[SEL_HOUR] = now_hour;
        now_v[SEL_DATE] = now_date;
    end

    rtc_alarm_rate u_rate (
        .masks    (masks),
        .rate     (rate),
        .field_en (field_en)
    );

    rtc_alarm_match u_match (
        .alarm_v  (fields),
        .now_v    (now_v),
        .field_en (field_en),
        .hit      (hit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DISARMED: begin
                if (armed && tick && hit) state_d = ST_FIRE;
                else if (armed)           state_d = ST_WATCH;
            end
            ST_WATCH: begin
                if (tick && hit) state_d = ST_FIRE;
            end
            ST_FIRE: begin
                state_d = ST_WATCH;
            end
            default: state_d = ST_DISARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DISARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        alarm_irq = (state_q == ST_FIRE);
    end

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |=> !alarm_irq);

    assert_pulse_needs_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_irq) |-> $past(tick));

    assert_quiet_until_date_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !alarm_irq);

    assert_every_second_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && tick && rate == RATE_EVERY_SEC && !alarm_irq) |=> alarm_irq);
endmodule

// File: tb/rtc_alarm_unit_tb.sv
`timescale 1ns/1ps
module rtc_alarm_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       tick = 1'b0;
    logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_date = '0;
    logic       alarm_irq;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    rtc_alarm_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tick(tick), .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_date(now_date), .alarm_irq(alarm_irq)
    );

    function automatic bit ok_59(input logic [7:0] v);
        int t, u;
        t = (v & 8'h7F) >> 4;
        u = v & 8'h0F;
        return (u <= 9) && (t <= 5);
    endfunction

    function automatic bit ok_23(input logic [7:0] v);
        int t, u;
        t = (v & 8'h3F) >> 4;
        u = v & 8'h0F;
        return (u <= 9) && ((t < 2) || (t == 2 && u <= 3));
    endfunction

    task automatic check(input bit got, input bit exp, input string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: alarm_irq=%0b expected %0b", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_all(input logic [7:0] s, input logic [7:0] m,
                           input logic [7:0] h, input logic [7:0] d);
        wr(2'd0, s); wr(2'd1, m); wr(2'd2, h); wr(2'd3, d);
    endtask

    // tick; irq must show in the following cycle and be gone one cycle later
    task automatic tick_chk(input logic [7:0] s, input logic [7:0] m,
                            input logic [7:0] h, input logic [7:0] d,
                            input bit exp, input string req);
        @(negedge clk);
        now_sec = s; now_min = m; now_hour = h; now_date = d; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check(alarm_irq, exp, req);
        @(negedge clk);
        check(alarm_irq, 1'b0, "R10");
    endtask

    initial begin
        #4000000;
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(alarm_irq, 1'b0, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        // R1: all fields zero, time zero, no date accepted -> silent
        tick_chk(8'h00, 8'h00, 8'h00, 8'h00, 1'b0, "R1 disarmed monthly");
        wr(2'd0, 8'h80);  // every-second mode, still disarmed
        tick_chk(8'h00, 8'h00, 8'h00, 8'h00, 1'b0, "R1 disarmed every-second");
        wr(2'd3, 8'h00);  // R4: zero date rejected, must not arm
        tick_chk(8'h00, 8'h00, 8'h00, 8'h00, 1'b0, "R4 zero date keeps disarmed");

        // R5 monthly
        set_all(8'h12, 8'h34, 8'h05, 8'h15);
        tick_chk(8'h12, 8'h34, 8'h05, 8'h15, 1'b1, "R5 monthly match");
        tick_chk(8'h12, 8'h34, 8'h05, 8'h16, 1'b0, "R5 monthly date differs");
        tick_chk(8'h12, 8'h34, 8'h06, 8'h15, 1'b0, "R5 monthly hour differs");
        tick_chk(8'h13, 8'h34, 8'h05, 8'h15, 1'b0, "R5 monthly sec differs");
        // R10: matching time without tick gives no pulse
        @(negedge clk);
        now_sec = 8'h12; now_min = 8'h34; now_hour = 8'h05; now_date = 8'h15;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(alarm_irq, 1'b0, "R10 no tick no pulse");
        end

        // R6 daily
        wr(2'd3, 8'h95);
        tick_chk(8'h12, 8'h34, 8'h05, 8'h28, 1'b1, "R6 daily ignores date");
        tick_chk(8'h12, 8'h34, 8'h07, 8'h15, 1'b0, "R6 daily hour differs");
        // R7 hourly
        wr(2'd2, 8'h85);
        tick_chk(8'h12, 8'h34, 8'h22, 8'h03, 1'b1, "R7 hourly ignores hour");
        tick_chk(8'h12, 8'h35, 8'h05, 8'h15, 1'b0, "R7 hourly min differs");
        // R8 minute
        wr(2'd1, 8'hB4);
        tick_chk(8'h12, 8'h59, 8'h11, 8'h01, 1'b1, "R8 minute ignores min");
        tick_chk(8'h40, 8'h34, 8'h05, 8'h15, 1'b0, "R8 minute sec differs");
        // R9 every second
        wr(2'd0, 8'h92);
        tick_chk(8'h40, 8'h01, 8'h02, 8'h03, 1'b1, "R9 all masks");
        set_all(8'h92, 8'h34, 8'h05, 8'h15);  // only second mask
        tick_chk(8'h00, 8'h00, 8'h00, 8'h01, 1'b1, "R9 sec mask only");
        set_all(8'h12, 8'hB4, 8'h05, 8'h95);  // date+min masks
        tick_chk(8'h00, 8'h00, 8'h00, 8'h01, 1'b1, "R9 date+min masks");

        // R11 write in the same cycle as tick
        set_all(8'h05, 8'h10, 8'h03, 8'h07);
        @(negedge clk);
        now_sec = 8'h06; now_min = 8'h10; now_hour = 8'h03; now_date = 8'h07;
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h06; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        check(alarm_irq, 1'b0, "R11 same-cycle write not seen");
        tick_chk(8'h06, 8'h10, 8'h03, 8'h07, 1'b1, "R11 seen at next tick");

        // R2 seconds sweep under minute rate
        set_all(8'h00, 8'h80, 8'h80, 8'h81);
        for (int v = 0; v < 256; v++) begin
            wr(2'd0, 8'h00);
            wr(2'd0, 8'(v));
            tick_chk(8'(v) & 8'h7F, 8'h00, 8'h00, 8'h00, ok_59(8'(v)), "R2 sec accept");
        end
        // R2 minutes sweep under hourly rate
        set_all(8'h00, 8'h00, 8'h80, 8'h81);
        for (int v = 0; v < 256; v++) begin
            wr(2'd1, 8'h00);
            wr(2'd1, 8'(v));
            tick_chk(8'h00, 8'(v) & 8'h7F, 8'h00, 8'h00, ok_59(8'(v)), "R2 min accept");
        end
        // R3 hours sweep under daily rate
        set_all(8'h00, 8'h00, 8'h00, 8'h81);
        for (int v = 0; v < 256; v++) begin
            wr(2'd2, 8'h00);
            wr(2'd2, 8'(v));
            tick_chk(8'h00, 8'h00, 8'(v) & 8'h3F, 8'h00, ok_23(8'(v)), "R3 hour accept");
        end
        // R4 date sweep under monthly rate
        set_all(8'h00, 8'h00, 8'h00, 8'h01);
        for (int v = 0; v < 256; v++) begin
            wr(2'd3, 8'h01);
            wr(2'd3, 8'(v));
            tick_chk(8'h00, 8'h00, 8'h00, 8'(v) & 8'h3F, (v & 8'h1F) != 0, "R4 date accept");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule